// File: doc/BRIEF.md
# External Signal Edge Timestamper

This block records when edges arrive on two asynchronous external lines. One line is an accelerator clock/data line that carries a 10 Mbit/s Manchester stream. The other is a strobe that marks message boundaries. Every time is read from a local 64-bit free-running count that advances once per master-clock cycle. The master clock is nominally 62.5 MHz.

Both lines pass through a two-flop synchroniser, and an edge is detected by comparing the last two synchronised samples. The recorded time is corrected for that pipeline, so it equals the count value at the clock edge that first sampled the new level. Both edges of the strobe are recorded. Only every Nth rising edge of the clock/data line is recorded, which keeps the readout rate far below the raw edge rate. Records leave through a small FIFO with a valid/ready handshake.

A phase monitor measures the master-cycle distance between successive selected clock-line edges. It raises a flag when that distance falls outside a programmable window. A loss counter counts every record that is dropped.

Top module: `edge_stamper`

## Requirements
- R1: The time field of a record equals the value of the master count at the first clock edge that sampled the new input level. The count is 0 at the first clock edge after reset is released and increases by one at each later edge.
- R2: A record is 66 bits wide. Bit 65 is the source (1 = strobe, 0 = clock/data line), bit 64 is the polarity (1 = rising), and bits 63:0 hold the time.
- R3: Every rising edge and every falling edge of the strobe produces a record.
- R4: Falling edges of the clock/data line never produce a record. Among its rising edges, only every Nth one produces a record, where N is the value of `decimN` and a value of 0 acts as 1. The count of rising edges restarts after each selected edge.
- R5: Records leave in arrival order. While `recValid` is high and `recReady` is low, `recValid` stays high and `recData` does not change. `recValid` is low when no records are held.
- R6: A capture that arrives while the FIFO holds FIFO_DEPTH records is discarded, and `overflowCount` increases by one. The counter saturates at its maximum value.
- R7: When a strobe edge and a selected clock-line edge are detected in the same cycle, only the strobe record is written. The lost clock-line record adds one to `overflowCount`.
- R8: After the second selected clock-line edge, `periodCount` holds the difference between the time values of the two most recent selected clock-line edges.
- R9: At each selected clock-line edge that has a predecessor, `phaseAlarm` is set to 1 if the distance lies outside the inclusive window `winLo`..`winHi`, and to 0 if it lies inside. At all other times `phaseAlarm` holds its value.
- R10: After reset, `recValid`, `overflowCount`, `periodCount` and `phaseAlarm` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkLineIn | input | 1 | Asynchronous accelerator clock/data line |
| strobeIn | input | 1 | Asynchronous message-boundary strobe |
| decimN | input | DEC_W | Decimation ratio for clock-line rising edges (0 acts as 1) |
| winLo | input | PER_W | Lower bound of the allowed edge distance, inclusive |
| winHi | input | PER_W | Upper bound of the allowed edge distance, inclusive |
| recReady | input | 1 | Consumer accepts the record at the FIFO head |
| recValid | output | 1 | A record is available |
| recData | output | 66 | Record: source, polarity, 64-bit time |
| overflowCount | output | OVF_W | Saturating count of lost records |
| periodCount | output | PER_W | Latest distance between selected clock-line edges |
| phaseAlarm | output | 1 | Latest distance lies outside the window |

## Verification
The clock/data line is driven as square waves of several half-periods, with the ratio set to 1, to 3 and to 0. This separates the handling of rising and falling edges, the decimation phase carried across runs, and the zero-acts-as-one rule. The same waves place the measured distance inside and then outside the window, so both values of the alarm are seen.

Bursts of strobe edges check both polarities. A burst longer than the FIFO, driven with the consumer stalled, checks ordering, the hold behaviour of the head record and the counting of drops. A strobe edge that coincides with a selected clock-line edge checks the priority rule. Every expected time is computed from the bench's own count of cycles since reset.

// File: rtl/es_pkg.sv
package es_pkg;
  localparam int TS_W  = 64;
  localparam int REC_W = TS_W + 2;

  // Capture command from the control half to the datapath half
  typedef struct packed {
    logic push;    // write one record this cycle
    logic src;     // 1 = strobe, 0 = clock/data line
    logic rising;  // edge polarity
    logic lost;    // a clock-line record was displaced by a strobe record
  } capCmd_t;
endpackage

// File: rtl/es_ctrl.sv
module es_ctrl
  import es_pkg::*;
#(
  parameter int DEC_W = 8,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkLineIn,
  input  logic             strobeIn,
  input  logic [DEC_W-1:0] decimN,
  input  logic [PER_W-1:0] winLo,
  input  logic [PER_W-1:0] winHi,
  output capCmd_t          cmd,
  output logic [PER_W-1:0] periodCount,
  output logic             phaseAlarm
);
  localparam int NCH = 2;  // channel 0 = clock line, 1 = strobe

  logic [NCH-1:0] rawIn, syncA, syncB, lastS, riseE, fallE;
  assign rawIn = {strobeIn, clkLineIn};

  for (genvar g = 0; g < NCH; g++) begin : gChan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA[g] <= 1'b0;
        syncB[g] <= 1'b0;
        lastS[g] <= 1'b0;
      end else begin
        syncA[g] <= rawIn[g];
        syncB[g] <= syncA[g];
        lastS[g] <= syncB[g];
      end
    end
    assign riseE[g] = syncB[g] & ~lastS[g];
    assign fallE[g] = ~syncB[g] & lastS[g];
  end

  // Decimation of clock-line rising edges
  logic [DEC_W-1:0] nEff, decCnt;
  logic clkSel, strobeEv;
  assign nEff     = (decimN == '0) ? DEC_W'(1) : decimN;
  assign clkSel   = riseE[0] && (decCnt >= nEff - 1'b1);
  assign strobeEv = riseE[1] | fallE[1];

  always_ff @(posedge clk) begin
    if (!rstN) decCnt <= '0;
    else if (riseE[0]) decCnt <= clkSel ? '0 : decCnt + 1'b1;
  end

  always_comb begin
    cmd.push   = strobeEv | clkSel;
    cmd.src    = strobeEv;
    cmd.rising = strobeEv ? riseE[1] : 1'b1;
    cmd.lost   = strobeEv & clkSel;
  end

  // Phase monitor
  logic [PER_W-1:0] runCnt;
  logic havePrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt      <= '0;
      havePrev    <= 1'b0;
      periodCount <= '0;
      phaseAlarm  <= 1'b0;
    end else if (clkSel) begin
      runCnt   <= PER_W'(1);
      havePrev <= 1'b1;
      if (havePrev) begin
        periodCount <= runCnt;
        phaseAlarm  <= (runCnt < winLo) || (runCnt > winHi);
      end
    end else if (runCnt != '1) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // R9
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkSel |=> $stable(phaseAlarm));

  // R4
  fall_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fallE[0] && !strobeEv) |-> !cmd.push);
endmodule

// File: rtl/es_data.sv
module es_data
  import es_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int OVF_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  capCmd_t          cmd,
  input  logic             recReady,
  output logic             recValid,
  output logic [REC_W-1:0] recData,
  output logic [OVF_W-1:0] overflowCount
);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam logic [TS_W-1:0] PIPE_LAT = TS_W'(2);

  logic [TS_W-1:0]  tsCount, stamp;
  logic [REC_W-1:0] mem [FIFO_DEPTH];
  logic [AW:0]      wrPtr, rdPtr;
  logic full, empty, doPush, doPop;
  logic [1:0]       lossInc;
  logic [OVF_W:0]   ovfSum;

  always_ff @(posedge clk) begin
    if (!rstN) tsCount <= '0;
    else tsCount <= tsCount + 1'b1;
  end
  assign stamp = tsCount - PIPE_LAT;

  assign empty  = (wrPtr == rdPtr);
  assign full   = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign doPush = cmd.push && !full;
  assign doPop  = recValid && recReady;
  assign recValid = !empty;
  assign recData  = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr[AW-1:0]] <= {cmd.src, cmd.rising, stamp};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  assign lossInc = {1'b0, cmd.push && full} + {1'b0, cmd.lost};
  assign ovfSum  = {1'b0, overflowCount} + {{(OVF_W-1){1'b0}}, lossInc};

  always_ff @(posedge clk) begin
    if (!rstN) overflowCount <= '0;
    else if (lossInc != 2'd0) overflowCount <= ovfSum[OVF_W] ? '1 : ovfSum[OVF_W-1:0];
  end

  // R1
  ts_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    tsCount != '0 |-> tsCount == $past(tsCount) + 1'b1);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && !recReady) |=> (recValid && $stable(recData)));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.push && full && overflowCount != '1) |=> overflowCount > $past(overflowCount));
endmodule

// File: rtl/edge_stamper.sv
module edge_stamper
  import es_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int DEC_W      = 8,
  parameter int PER_W      = 16,
  parameter int OVF_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkLineIn,
  input  logic             strobeIn,
  input  logic [DEC_W-1:0] decimN,
  input  logic [PER_W-1:0] winLo,
  input  logic [PER_W-1:0] winHi,
  input  logic             recReady,
  output logic             recValid,
  output logic [65:0]      recData,
  output logic [OVF_W-1:0] overflowCount,
  output logic [PER_W-1:0] periodCount,
  output logic             phaseAlarm
);
  capCmd_t cmd;

  es_ctrl #(.DEC_W(DEC_W), .PER_W(PER_W)) uCtrl (
    .clk(clk), .rstN(rstN), .clkLineIn(clkLineIn), .strobeIn(strobeIn),
    .decimN(decimN), .winLo(winLo), .winHi(winHi), .cmd(cmd),
    .periodCount(periodCount), .phaseAlarm(phaseAlarm)
  );

  es_data #(.FIFO_DEPTH(FIFO_DEPTH), .OVF_W(OVF_W)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .recReady(recReady),
    .recValid(recValid), .recData(recData), .overflowCount(overflowCount)
  );
endmodule

// File: tb/tb_edge_stamper.sv
`timescale 1ns/1ps
module tb_edge_stamper;
  localparam int DEC_W = 4;
  localparam int PER_W = 16;
  localparam int OVF_W = 8;
  localparam int DEPTH = 4;

  logic clk = 0, rstN = 0, clkLine = 0, stb = 0, recReady = 0;
  logic [DEC_W-1:0] decimN = 1;
  logic [PER_W-1:0] winLo = 5, winHi = 7;
  logic recValid, phaseAlarm;
  logic [65:0] recData;
  logic [OVF_W-1:0] overflowCount;
  logic [PER_W-1:0] periodCount;

  always #2 clk = ~clk;

  edge_stamper #(.FIFO_DEPTH(DEPTH), .DEC_W(DEC_W), .PER_W(PER_W), .OVF_W(OVF_W)) dut (
    .clk(clk), .rstN(rstN), .clkLineIn(clkLine), .strobeIn(stb), .decimN(decimN),
    .winLo(winLo), .winHi(winHi), .recReady(recReady), .recValid(recValid),
    .recData(recData), .overflowCount(overflowCount), .periodCount(periodCount),
    .phaseAlarm(phaseAlarm)
  );

  logic [63:0] cyc = 0;
  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  int nChk = 0, nBad = 0;
  logic [65:0] expQ [0:63];
  int wIdx = 0, rIdx = 0, decB = 0, ovfExp = 0;
  logic [63:0] lastSel = 0, perExp = 0;
  bit havePrevB = 0, alarmExp = 0;

  task automatic check(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void addRec(input bit src, input bit pol, input logic [63:0] st);
    if (wIdx - rIdx >= DEPTH) ovfExp++;
    else begin expQ[wIdx % 64] = {src, pol, st}; wIdx++; end
  endfunction

  // model of decimation and phase monitor; returns 1 when the edge is selected
  function automatic bit clkRise(input logic [63:0] st);
    int nEff = (decimN == 0) ? 1 : int'(decimN);
    if (decB >= nEff - 1) begin
      decB = 0;
      if (havePrevB) begin
        perExp = st - lastSel;
        alarmExp = (perExp < 64'(winLo)) || (perExp > 64'(winHi));
      end
      lastSel = st; havePrevB = 1;
      return 1;
    end
    decB++;
    return 0;
  endfunction

  task automatic edgeClk(input bit lvl, input int gap);
    logic [63:0] st;
    @(negedge clk);
    st = cyc; clkLine = lvl;
    if (lvl && clkRise(st)) addRec(0, 1, st);
    repeat (gap - 1) @(posedge clk);
  endtask

  task automatic wave(input int rises, input int half);
    for (int i = 0; i < rises; i++) begin
      edgeClk(1, half);
      edgeClk(0, half);
    end
  endtask

  task automatic edgeStb(input bit lvl, input int gap);
    logic [63:0] st;
    @(negedge clk);
    st = cyc; stb = lvl;
    addRec(1, lvl, st);
    repeat (gap - 1) @(posedge clk);
  endtask

  task automatic drain(input string tag);
    repeat (3) @(posedge clk);
    @(negedge clk);
    recReady = 1;
    while (rIdx != wIdx) begin
      check(recValid && recData === expQ[rIdx % 64], tag, recData, expQ[rIdx % 64]);
      rIdx++;
      @(negedge clk);
    end
    check(!recValid, "R5 empty after drain", 66'(recValid), 66'd0);
    check(overflowCount == OVF_W'(ovfExp), "R6/R7 loss count", 66'(overflowCount), 66'(ovfExp));
    recReady = 0;
  endtask

  task automatic checkPhase(input string tag);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(64'(periodCount) == perExp, {tag, " R8 period"}, 66'(periodCount), 66'(perExp));
    check(phaseAlarm == alarmExp, {tag, " R9 alarm"}, 66'(phaseAlarm), 66'(alarmExp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    check(!recValid, "R10 valid", 66'(recValid), 0);
    check(overflowCount == 0, "R10 loss", 66'(overflowCount), 0);
    check(periodCount == 0 && !phaseAlarm, "R10 phase", 66'({periodCount, phaseAlarm}), 0);

    // N=1, period 6, inside window 5..7: R1 R2 R4
    decimN = 1;
    wave(3, 3);
    checkPhase("N1");
    drain("R1/R2/R4 n1");

    // N=3, period 12, outside window
    decimN = 3;
    wave(7, 2);
    checkPhase("N3 out");
    drain("R4 n3");

    // window moved to 10..14, same spacing
    winLo = 10; winHi = 14;
    wave(6, 2);
    checkPhase("N3 in");
    drain("R4 n3b");

    // N=0 behaves as 1, period 8 below window
    decimN = 0;
    wave(2, 4);
    checkPhase("N0");
    drain("R4 n0");

    // strobe both polarities: R3
    edgeStb(1, 2); edgeStb(0, 3); edgeStb(1, 1); edgeStb(0, 2);
    drain("R3 strobe");

    // overflow with consumer stalled: R5 hold, R6 drop
    for (int i = 0; i < 6; i++) edgeStb(i % 2 == 0, 2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(recData === expQ[rIdx % 64], "R5 head", recData, expQ[rIdx % 64]);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(recValid && recData === expQ[rIdx % 64], "R5 hold", recData, expQ[rIdx % 64]);
    drain("R6 order");

    // collision of strobe edge and selected clock-line edge: R7
    decimN = 1;
    begin
      logic [63:0] st;
      @(negedge clk);
      st = cyc; stb = 1; clkLine = 1;
      if (clkRise(st)) ovfExp++;
      addRec(1, 1, st);
      repeat (4) @(posedge clk);
    end
    drain("R7 collision");
    edgeClk(0, 3);
    drain("R4 fall after R7");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule